// File: doc/BRIEF.md
# Segmented 22-Bit Arithmetic/Logic Coprocessor

This block is a bus-attached arithmetic and logic unit that works on two 22-bit operands with a single 8-bit datapath slice. A host loads operand A and operand B one byte at a time over an 8-bit write bus. Each operand has its own device-select code, and each operand keeps its own byte pointer that starts at the least significant byte. A write of a 6-bit operation code to a fourth select code starts the unit. The unit then passes the slice over the three segments in turn, lowest segment first. It keeps the carry (or borrow) in a register between segments, so the three partial results join into one exact 22-bit result. The top segment holds only 6 valid bits.

After completion the host reads the three result bytes back, lowest first, through a third select code. It tests the zero and overflow flags for control decisions. Every bus access passes through one register stage before it takes effect, so the decode and the data are aligned to the clock. While the unit is computing, every bus access is dropped.

Top module: `segalu_top`

## Requirements
- R1: After a cycle with `rst_n` low, `busy`, `zero_flag`, `ovf_flag` and `rdata` are 0. Both operands, the result and all byte pointers are 0.
- R2: An access with `dev_sel`=1 and `rw`=1 writes `wdata` into the next byte of operand A, in the order byte 0 (bits 7:0), byte 1, byte 2, then back to byte 0. The write takes effect on the second rising edge after it is presented. Only bits 5:0 of byte 2 enter the computation.
- R3: An access with `dev_sel`=2 and `rw`=1 loads operand B in the same way as R2, with its own pointer.
- R4: An access with `dev_sel`=4 and `rw`=1 latches `wdata[5:0]` as the operation code. It also returns the A, B and read pointers to byte 0. `busy` rises at the second rising edge after the access and stays high for exactly 3 cycles.
- R5: Code 0x01 adds: result = (A+B) mod 2^22. `ovf_flag` is the carry out of bit 21, and the carry passes between every pair of segments.
- R6: Code 0x02 subtracts: result = (A−B) mod 2^22. `ovf_flag` is 1 exactly when B > A.
- R7: Code 0x08 gives AND, 0x09 gives OR and 0x0A gives XOR. Every other code passes A to the result. For all of these `ovf_flag` is 0.
- R8: `zero_flag` is 1 exactly when all 22 result bits are 0. Both flags change on the edge where `busy` falls.
- R9: An access with `dev_sel`=3 and `rw`=0 loads `rdata` with the next result byte, in the order byte 0, 1, 2, then byte 0 again. `rdata` changes on the second rising edge after the access and holds between reads.
- R10: Any access that reaches the register stage output while `busy` is high has no effect on operands, code, pointers or `rdata`.
- R11: An access whose `rw` level does not fit its select code has no effect. This covers `dev_sel` 1, 2 or 4 with `rw`=0, and `dev_sel` 3 with `rw`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_sel | input | 4 | Device-select code; 0 is idle |
| rw | input | 1 | 1 = write, 0 = read |
| wdata | input | 8 | Write data: operand byte or operation code |
| rdata | output | 8 | Last result byte read |
| busy | output | 1 | High while segments are being processed |
| zero_flag | output | 1 | Result of the last operation is zero |
| ovf_flag | output | 1 | Carry/borrow out of bit 21 of the last operation |

## Verification
Operand and code accesses take effect two edges after they are presented. `busy` is high from that edge for three cycles, and the flags and result settle on the edge where `busy` falls, five edges after the code write. `rdata` follows a read two edges later. The bench model applies each access to its own state one edge after it captures it, ignores it when its own busy count is running, and publishes the result when the count expires. All outputs are compared with the model on every falling edge. Directed checks at those same falling edges target the timing of the `busy` window, the carry and borrow across segment boundaries, the masking of the top segment, and accesses dropped while busy or with the wrong direction.

// File: rtl/segalu_pkg.sv
// Shared parameters, select codes, operation codes and the bus request type
// for the segmented ALU. Assumes the word is at most three 8-bit segments wide.
package segalu_pkg;
    localparam int WORD_W = 22;
    localparam int SEG_W  = 8;
    localparam int NSEG   = (WORD_W + SEG_W - 1) / SEG_W;
    localparam int TOP_W  = WORD_W - SEG_W * (NSEG - 1);
    localparam int SEG_CW = $clog2(NSEG);
    localparam int OP_W   = 6;
    localparam int SEL_W  = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_IDLE = 4'd0,
        SEL_OPA  = 4'd1,
        SEL_OPB  = 4'd2,
        SEL_RES  = 4'd3,
        SEL_CMD  = 4'd4
    } dev_sel_e;

    localparam logic [OP_W-1:0] OP_ADD = 6'h01;
    localparam logic [OP_W-1:0] OP_SUB = 6'h02;
    localparam logic [OP_W-1:0] OP_AND = 6'h08;
    localparam logic [OP_W-1:0] OP_OR  = 6'h09;
    localparam logic [OP_W-1:0] OP_XOR = 6'h0A;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             wr;
        logic [SEG_W-1:0] data;
    } bus_req_t;
endpackage

// File: rtl/segalu_bus_sync.sv
// Registers one bus access so that select decode and data are aligned to clk.
// Assumes the host holds each access for one clock.
module segalu_bus_sync
    import segalu_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  bus_req_t req_i,
    output bus_req_t req_o
);
    // Capture the access; idle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) req_o <= '0;
        else        req_o <= req_i;
    end
endmodule

// File: rtl/segalu_operand_bank.sv
// One operand store: bytes written in sequence from the lowest segment,
// pointer wrapping after the top segment. Assumes wr_i and clr_i never coincide.
module segalu_operand_bank #(
    parameter int NS  = segalu_pkg::NSEG,
    parameter int SW  = segalu_pkg::SEG_W,
    localparam int PW = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_i,
    input  logic           clr_i,
    input  logic [SW-1:0]  wdata_i,
    output logic [NS*SW-1:0] word_o
);
    logic [PW-1:0] ptr_q;

    // Store the byte at the current pointer and advance or clear the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o <= '0;
            ptr_q  <= '0;
        end else if (clr_i) begin
            ptr_q  <= '0;
        end else if (wr_i) begin
            word_o[ptr_q*SW +: SW] <= wdata_i;
            ptr_q <= (ptr_q == PW'(NS-1)) ? '0 : ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/segalu_slice_engine.sv
// Sequences one 8-bit slice over all segments, lowest first, keeping the carry
// in a register between segments. The top segment is masked to its valid bits.
// Flags settle on the last segment. Assumes start_i only arrives while idle.
module segalu_slice_engine
    import segalu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [OP_W-1:0]       op_i,
    input  logic [NSEG*SEG_W-1:0] a_i,
    input  logic [NSEG*SEG_W-1:0] b_i,
    output logic                  busy_o,
    output logic [NSEG*SEG_W-1:0] res_o,
    output logic                  zero_o,
    output logic                  ovf_o
);
    localparam logic [SEG_W-1:0] TOP_MASK = SEG_W'((1 << TOP_W) - 1);

    logic [OP_W-1:0]   op_q;
    logic [SEG_CW-1:0] seg_q;
    logic              carry_q, zacc_q;
    logic              is_top, is_sub, is_add, cout;
    logic [SEG_W-1:0]  mask, a_m, b_m, b_eff, slice_res;
    logic [SEG_W:0]    sum;

    // Slice datapath for the current segment.
    always_comb begin
        is_top = (seg_q == SEG_CW'(NSEG - 1));
        is_sub = (op_q == OP_SUB);
        is_add = (op_q == OP_ADD);
        mask   = is_top ? TOP_MASK : '1;
        a_m    = a_i[seg_q*SEG_W +: SEG_W] & mask;
        b_m    = b_i[seg_q*SEG_W +: SEG_W] & mask;
        b_eff  = (is_sub ? ~b_m : b_m) & mask;
        sum    = {1'b0, a_m} + {1'b0, b_eff} + {{SEG_W{1'b0}}, carry_q};
        cout   = is_top ? sum[TOP_W] : sum[SEG_W];
        case (op_q)
            OP_ADD, OP_SUB: slice_res = sum[SEG_W-1:0];
            OP_AND:         slice_res = a_m & b_m;
            OP_OR:          slice_res = a_m | b_m;
            OP_XOR:         slice_res = a_m ^ b_m;
            default:        slice_res = a_m;
        endcase
        slice_res = slice_res & mask;
    end

    // Segment sequencer, carry chain, result bytes and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= '0;
            seg_q   <= '0;
            carry_q <= 1'b0;
            zacc_q  <= 1'b0;
            busy_o  <= 1'b0;
            res_o   <= '0;
            zero_o  <= 1'b0;
            ovf_o   <= 1'b0;
        end else if (start_i) begin
            op_q    <= op_i;
            seg_q   <= '0;
            carry_q <= (op_i == OP_SUB);
            zacc_q  <= 1'b1;
            busy_o  <= 1'b1;
        end else if (busy_o) begin
            res_o[seg_q*SEG_W +: SEG_W] <= slice_res;
            carry_q <= cout;
            zacc_q  <= zacc_q & (slice_res == '0);
            if (is_top) begin
                busy_o <= 1'b0;
                zero_o <= zacc_q & (slice_res == '0);
                ovf_o  <= is_add ? cout : (is_sub ? ~cout : 1'b0);
            end else begin
                seg_q <= seg_q + 1'b1;
            end
        end
    end

    // R4
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(busy_o, 3) && !$past(busy_o, 4)));

    // R7
    logic_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && op_q != OP_ADD && op_q != OP_SUB) |-> !ovf_o);

    // R8
    zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && zero_o) |-> (res_o == '0));
endmodule

// File: rtl/segalu_top.sv
// Bus-attached segmented ALU: decodes the registered access into operand loads,
// a start command and result reads, and drops every access while busy.
// Assumes one access per clock at most; dev_sel 0 is idle.
module segalu_top
    import segalu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] dev_sel,
    input  logic             rw,
    input  logic [SEG_W-1:0] wdata,
    output logic [SEG_W-1:0] rdata,
    output logic             busy,
    output logic             zero_flag,
    output logic             ovf_flag
);
    bus_req_t              req_q;
    logic                  ld_a, ld_b, ld_op, rd_res;
    logic [NSEG*SEG_W-1:0] a_word, b_word, res_word;
    logic [SEG_CW-1:0]     rptr_q;

    segalu_bus_sync u_sync (
        .clk(clk), .rst_n(rst_n),
        .req_i('{sel: dev_sel, wr: rw, data: wdata}),
        .req_o(req_q)
    );

    // Decode the registered access; nothing is accepted while busy.
    always_comb begin
        ld_a   = !busy && req_q.wr  && (req_q.sel == SEL_OPA);
        ld_b   = !busy && req_q.wr  && (req_q.sel == SEL_OPB);
        ld_op  = !busy && req_q.wr  && (req_q.sel == SEL_CMD);
        rd_res = !busy && !req_q.wr && (req_q.sel == SEL_RES);
    end

    segalu_operand_bank u_bank_a (
        .clk(clk), .rst_n(rst_n), .wr_i(ld_a), .clr_i(ld_op),
        .wdata_i(req_q.data), .word_o(a_word)
    );

    segalu_operand_bank u_bank_b (
        .clk(clk), .rst_n(rst_n), .wr_i(ld_b), .clr_i(ld_op),
        .wdata_i(req_q.data), .word_o(b_word)
    );

    segalu_slice_engine u_engine (
        .clk(clk), .rst_n(rst_n), .start_i(ld_op),
        .op_i(req_q.data[OP_W-1:0]), .a_i(a_word), .b_i(b_word),
        .busy_o(busy), .res_o(res_word), .zero_o(zero_flag), .ovf_o(ovf_flag)
    );

    // Result read-back register and its byte pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rptr_q <= '0;
        end else if (ld_op) begin
            rptr_q <= '0;
        end else if (rd_res) begin
            rdata  <= res_word[rptr_q*SEG_W +: SEG_W];
            rptr_q <= (rptr_q == SEG_CW'(NSEG - 1)) ? '0 : rptr_q + 1'b1;
        end
    end

    // R10
    busy_hold_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(rptr_q) && $stable(rdata)));

    // R10
    busy_hold_opnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(a_word) && $stable(b_word)));
endmodule

// File: tb/sim_segalu_top.sv
// Bench: a behavioural model advanced on each rising edge and compared with the
// outputs on every falling edge, plus directed checks per requirement.
module sim_segalu_top;
    localparam int CLK_PERIOD = 10;
    localparam int MASK22 = 32'h3FFFFF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] dev_sel = '0;
    logic       rw = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       busy, zero_flag, ovf_flag;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit armed = 1'b0;
    bit done = 1'b0;

    segalu_top u0 (
        .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .rw(rw), .wdata(wdata),
        .rdata(rdata), .busy(busy), .zero_flag(zero_flag), .ovf_flag(ovf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural model state.
    int unsigned m_a, m_b, m_res, p_res;
    int m_aptr, m_bptr, m_rptr, m_cnt;
    bit m_busy, m_zero, m_ovf, p_ovf;
    int m_rdata;
    int s_sel, s_data;
    bit s_wr;

    function automatic int unsigned put_byte(int unsigned w, int p, int d);
        return (w & ~(32'hFF << (8*p))) | ((d & 8'hFF) << (8*p));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_a = 0; m_b = 0; m_res = 0; p_res = 0;
            m_aptr = 0; m_bptr = 0; m_rptr = 0; m_cnt = 0;
            m_busy = 0; m_zero = 0; m_ovf = 0; p_ovf = 0; m_rdata = 0;
            s_sel = 0; s_data = 0; s_wr = 0;
        end else begin
            automatic bit was_busy = m_busy;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 0; m_res = p_res; m_ovf = p_ovf; m_zero = (p_res == 0);
                end
            end
            if (!was_busy) begin
                if (s_sel == 1 && s_wr) begin
                    m_a = put_byte(m_a, m_aptr, s_data); m_aptr = (m_aptr + 1) % 3;
                end else if (s_sel == 2 && s_wr) begin
                    m_b = put_byte(m_b, m_bptr, s_data); m_bptr = (m_bptr + 1) % 3;
                end else if (s_sel == 3 && !s_wr) begin
                    m_rdata = (m_res >> (8*m_rptr)) & 8'hFF; m_rptr = (m_rptr + 1) % 3;
                end else if (s_sel == 4 && s_wr) begin
                    automatic int unsigned a = m_a & MASK22;
                    automatic int unsigned b = m_b & MASK22;
                    automatic int op = s_data & 6'h3F;
                    p_ovf = 0;
                    case (op)
                        1: begin p_res = (a + b) & MASK22; p_ovf = ((a + b) >> 22) != 0; end
                        2: begin p_res = (a - b) & MASK22; p_ovf = (b > a); end
                        8: p_res = a & b;
                        9: p_res = a | b;
                        10: p_res = a ^ b;
                        default: p_res = a;
                    endcase
                    m_cnt = 3; m_busy = 1; m_aptr = 0; m_bptr = 0; m_rptr = 0;
                end
            end
            s_sel = dev_sel; s_wr = rw; s_data = wdata;
        end
        armed = 1'b1;
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (armed && !done) begin
            check(cur_req, "busy", busy, m_busy);
            check(cur_req, "zero_flag", zero_flag, m_zero);
            check(cur_req, "ovf_flag", ovf_flag, m_ovf);
            check(cur_req, "rdata", rdata, m_rdata);
        end
    end

    task automatic bus(int sel, bit w, int d);
        @(negedge clk);
        dev_sel = 4'(sel); rw = w; wdata = 8'(d);
        @(negedge clk);
        dev_sel = '0; rw = 1'b0; wdata = '0;
    endtask

    task automatic load(int sel, int unsigned v);
        for (int i = 0; i < 3; i++) bus(sel, 1'b1, (v >> (8*i)) & 8'hFF);
    endtask

    task automatic run_op(int op);
        bus(4, 1'b1, op);
        repeat (5) @(negedge clk);
    endtask

    task automatic read_byte(output int v);
        bus(3, 1'b0, 0);
        @(negedge clk);
        v = rdata;
    endtask

    task automatic op_test(string req, int unsigned a, int unsigned b, int op,
                           int unsigned exp, bit ez, bit eo);
        int v;
        cur_req = req;
        load(1, a); load(2, b); run_op(op);
        check(req, "zero_flag", zero_flag, ez);
        check(req, "ovf_flag", ovf_flag, eo);
        for (int i = 0; i < 3; i++) begin
            read_byte(v);
            check(req, "result byte", v, (exp >> (8*i)) & 8'hFF);
        end
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "busy", busy, 0);
        check("R1", "zero_flag", zero_flag, 0);
        check("R1", "ovf_flag", ovf_flag, 0);
        check("R1", "rdata", rdata, 0);
        rst_n = 1'b1;

        // R4: busy window timing
        cur_req = "R4";
        load(1, 32'h000010); load(2, 32'h000020);
        bus(4, 1'b1, 32'h01);
        check("R4", "busy after 1 edge", busy, 0);
        @(negedge clk); check("R4", "busy after 2 edges", busy, 1);
        @(negedge clk); check("R4", "busy after 3 edges", busy, 1);
        @(negedge clk); check("R4", "busy after 4 edges", busy, 1);
        @(negedge clk); check("R4", "busy after 5 edges", busy, 0);

        // R2 R3 R5: byte loads and add with carries between segments
        op_test("R5", 32'h012345, 32'h0ABCDE, 1, 32'h0BE023, 0, 0);
        // R5 R8: carry through all segments out of bit 21
        op_test("R8", 32'h3FFFFF, 32'h000001, 1, 0, 1, 1);
        // R2: top byte bits 7:6 ignored
        op_test("R2", 32'hFF00FF, 32'h000001, 1, 32'h3F0100, 0, 0);
        // R6: subtraction with and without borrow
        op_test("R6", 32'h000005, 32'h000007, 2, 32'h3FFFFE, 0, 1);
        op_test("R6", 32'h100000, 32'h0000FF, 2, 32'h0FFF01, 0, 0);
        op_test("R6", 32'h2A5A5A, 32'h2A5A5A, 2, 0, 1, 0);
        // R3: B top byte masked
        op_test("R3", 32'h000000, 32'hC00000, 9, 0, 1, 0);
        // R7: logic functions and pass-through
        op_test("R7", 32'h3C3C3C, 32'h0FF0FF, 8, 32'h0C303C, 0, 0);
        op_test("R7", 32'h3C3C3C, 32'h0FF0FF, 9, 32'h3FFCFF, 0, 0);
        op_test("R7", 32'h3C3C3C, 32'h0FF0FF, 10, 32'h33CCC3, 0, 0);
        op_test("R7", 32'h123456, 32'h3FFFFF, 6'h3F, 32'h123456, 0, 0);

        // R9: read pointer wraps to byte 0
        cur_req = "R9";
        read_byte(v); check("R9", "wrapped read", v, 8'h56);

        // R10: accesses during busy are dropped
        cur_req = "R10";
        load(1, 32'h000001); load(2, 32'h000002);
        bus(4, 1'b1, 1);
        bus(1, 1'b1, 8'h55);
        bus(3, 1'b0, 0);
        check("R10", "rdata held", rdata, 8'h56);
        repeat (4) @(negedge clk);
        run_op(1);
        read_byte(v); check("R10", "A unchanged", v, 8'h03);

        // R11: wrong direction has no effect
        cur_req = "R11";
        bus(1, 1'b0, 8'h77);
        bus(2, 1'b0, 8'h77);
        bus(3, 1'b1, 0);
        @(negedge clk); check("R11", "rdata held", rdata, 8'h03);
        bus(4, 1'b0, 2);
        @(negedge clk); check("R11", "no start", busy, 0);
        run_op(1);
        read_byte(v); check("R11", "operands unchanged", v, 8'h03);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        done = 1'b1;
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule